// File: doc/BRIEF.md
# PWM Compare Channel with Buffered Duty Value

This block is one compare channel that sits beside a shared free-running counter. It looks only at the counter's low byte, and only on cycles where the timebase enable `tick` is high. It produces one pulse-width-modulated output. Within each 256-count period the output goes high when the count reaches the active compare value. It drops again when the count wraps back to zero.

Software changes the duty cycle through three byte-write strobes. One writes the active compare value directly, one writes a buffer value, and one writes the mode register. The active value is reloaded from the buffer on every wrap, so a new duty value written mid-period starts cleanly at the next period. The compare-value writes also change the compare-enable bit. A direct write clears it and a buffer write sets it. A two-byte update written direct-value first therefore leaves the channel running. Clearing the enable gives a steady low output.

Top module: `pwm8_chan`

## Requirements
- R1: With the channel enabled and compare value C, the output is high for exactly the ticks whose count lies in C..255, so the duty is (256 - C)/256. The output changes one clock after the tick that causes the change.
- R2: On a tick at count 0x00 the output is cleared, unless a match also occurs on that tick.
- R3: On a tick at count 0x00 the active compare value is loaded from the buffer. A buffer write made mid-period leaves the rest of that period unchanged, and the new value governs the next period.
- R4: The channel is enabled only while both mode bits are 1: bit 0 is compare-enable and bit 1 is PWM-mode, both written through `wr_mode` from `wdata[1:0]`. While it is disabled, the output is low one clock later and stays low.
- R5: A write to the active compare value forces compare-enable to 0. A write to the buffer forces it to 1. These writes override a `wr_mode` write made in the same cycle, and a buffer write wins over a direct write.
- R6: A compare value of 0 holds the output constantly high. At count 0x00 the set wins over the wrap clear.
- R7: On cycles with `tick` low, the output and the compare registers hold their values.
- R8: After synchronous reset the output is low, both compare values are 0 and both mode bits are 0. Enabling the mode with no compare write therefore gives a constant high output.
- R9: A compare value of 0xFF gives exactly one high tick per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable; the counter value is evaluated when high |
| cnt_lo | input | 8 | Low byte of the shared counter |
| wr_lo | input | 1 | Write strobe for the active compare value |
| wr_hi | input | 1 | Write strobe for the buffered compare value |
| wr_mode | input | 1 | Write strobe for the mode bits |
| wdata | input | 8 | Write data for all strobes |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions assume that `cnt_lo` advances by exactly one per tick and passes through 0x00 on each wrap. They also assume that a direct compare write never falls on the same cycle as a wrap tick. The bench keeps to both conditions: it keeps its own counter, increments it only after a tick, and issues compare writes only on cycles where `tick` is low. Duty results are compared only once a full period has started after the last enable change. Until then, only the forced-low output of a disabled channel is checked.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  localparam int MODE_ECOM_BIT = 0;
  localparam int MODE_PWM_BIT  = 1;

  typedef struct packed {
    logic pwm;
    logic ecom;
  } mode_t;
endpackage

// File: rtl/pwm8_regs.sv
module pwm8_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic         wr_mode,
  input  logic [W-1:0] wdata,
  input  logic         reload,
  output logic [W-1:0] cmp_act,
  output logic [W-1:0] cmp_buf,
  output logic         en
);
  import pwm8_pkg::*;

  mode_t mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      cmp_act <= '0;
      cmp_buf <= '0;
    end else begin
      if (wr_mode) begin
        mode_q.ecom <= wdata[MODE_ECOM_BIT];
        mode_q.pwm  <= wdata[MODE_PWM_BIT];
      end
      if (wr_lo) mode_q.ecom <= 1'b0;
      if (wr_hi) mode_q.ecom <= 1'b1;
      if (wr_lo)       cmp_act <= wdata;
      else if (reload) cmp_act <= cmp_buf;
      if (wr_hi)       cmp_buf <= wdata;
    end
  end

  assign en = mode_q.ecom & mode_q.pwm;

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst) (reload && !wr_lo) |=> (cmp_act == $past(cmp_buf))); // R3
  AST_LO_CLEARS_EN: assert property (@(posedge clk) disable iff (rst) (wr_lo && !wr_hi) |=> !en); // R5
  AST_HI_SETS_ECOM: assert property (@(posedge clk) disable iff (rst) wr_hi |=> mode_q.ecom); // R5
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst) (!reload && !wr_lo && !wr_hi) |=> ($stable(cmp_act) && $stable(cmp_buf))); // R7
endmodule

// File: rtl/pwm8_cmp.sv
module pwm8_cmp #(
  parameter int W = 8
) (
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_act,
  input  logic [W-1:0] cmp_buf,
  output logic         wrap,
  output logic         match
);
  logic [W-1:0] eff_cmp;

  always_comb begin
    wrap    = tick && (cnt == '0);
    eff_cmp = wrap ? cmp_buf : cmp_act;
    match   = tick && (cnt == eff_cmp);
  end
endmodule

// File: rtl/pwm8_outq.sv
module pwm8_outq (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wrap,
  input  logic match,
  output logic pwm_out
);
  always_ff @(posedge clk) begin
    if (rst)        pwm_out <= 1'b0;
    else if (!en)   pwm_out <= 1'b0;
    else if (match) pwm_out <= 1'b1;
    else if (wrap)  pwm_out <= 1'b0;
  end

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst) !en |=> !pwm_out); // R4
  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst) (en && match) |=> pwm_out); // R1
  AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (rst) (wrap && !match) |=> !pwm_out); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (en && !wrap && !match) |=> $stable(pwm_out)); // R7
endmodule

// File: rtl/pwm8_chan.sv
module pwm8_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] cnt_lo,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic         wr_mode,
  input  logic [W-1:0] wdata,
  output logic         pwm_out
);
  logic [W-1:0] cmp_act;
  logic [W-1:0] cmp_buf;
  logic         en;
  logic         wrap;
  logic         match;

  pwm8_regs #(.W(W)) regs_i (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_mode(wr_mode),
    .wdata(wdata), .reload(wrap), .cmp_act(cmp_act), .cmp_buf(cmp_buf), .en(en)
  );

  pwm8_cmp #(.W(W)) cmp_i (
    .tick(tick), .cnt(cnt_lo), .cmp_act(cmp_act), .cmp_buf(cmp_buf),
    .wrap(wrap), .match(match)
  );

  pwm8_outq outq_i (
    .clk(clk), .rst(rst), .en(en), .wrap(wrap), .match(match), .pwm_out(pwm_out)
  );
endmodule

// File: tb/pwm8_chan_tb_top.sv
module pwm8_chan_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] cnt_lo = '0;
  logic       wr_lo = 1'b0, wr_hi = 1'b0, wr_mode = 1'b0;
  logic [7:0] wdata = '0;
  logic       pwm_out;

  always #2 clk = ~clk;

  pwm8_chan dut_i (
    .clk(clk), .rst(rst), .tick(tick), .cnt_lo(cnt_lo), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .wr_mode(wr_mode), .wdata(wdata), .pwm_out(pwm_out)
  );

  typedef struct {
    bit    valid;
    logic  exp;
    string tag;
  } item_t;

  item_t sbq[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_tag = "R8";

  logic [7:0] cnt = '0;
  logic       m_ecom = 0, m_pwm = 0;
  logic [7:0] m_buf = '0, m_per = '0;
  logic       m_clean = 0, m_last = 0;

  task automatic step(input bit tk, input bit wl, input bit wh, input bit wm, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    tick = tk; cnt_lo = cnt; wr_lo = wl; wr_hi = wh; wr_mode = wm; wdata = d;
    it.valid = 1; it.tag = cur_tag; it.exp = 0;
    if (!(m_ecom && m_pwm)) begin
      it.exp = 0; m_clean = 0;
    end else if (tk) begin
      if (cnt == 8'h00) begin
        m_per = m_buf; m_clean = 1;
        it.tag = (m_per == 0) ? "R6" : "R2";
      end
      if (m_clean) it.exp = (cnt >= m_per);
      else it.valid = 0;
    end else begin
      it.exp = m_last; it.valid = m_clean;
    end
    m_last = it.exp;
    sbq.push_back(it);
    if (wm) begin m_ecom = d[0]; m_pwm = d[1]; end
    if (wl) m_ecom = 0;
    if (wh) begin m_ecom = 1; m_buf = d; end
    if (tk) cnt = cnt + 8'd1;
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1, 0, 0, 0, 8'h00);
      for (int g = 0; g < gap; g++) step(0, 0, 0, 0, 8'h00);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      if (it.valid) begin
        n_cmp++;
        if (pwm_out !== it.exp) begin
          n_bad++;
          $display("FAIL %s: pwm_out=%b expected=%b", it.tag, pwm_out, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    n_cmp++;
    if (pwm_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R8: reset pwm_out=%b expected=0", pwm_out);
    end
    cur_tag = "R4"; run(260, 0);
    cur_tag = "R8"; step(0, 0, 0, 1, 8'h03); run(300, 0);
    cur_tag = "R1"; step(0, 1, 0, 0, 8'h40); step(0, 0, 1, 0, 8'h40); run(600, 0);
    cur_tag = "R3";
    while (cnt != 8'h80) run(1, 0);
    step(0, 0, 1, 0, 8'hC0); run(600, 0);
    cur_tag = "R7"; run(520, 2);
    cur_tag = "R9"; step(0, 0, 1, 0, 8'hFF); run(600, 0);
    cur_tag = "R6"; step(0, 0, 1, 0, 8'h00); run(600, 0);
    cur_tag = "R5"; step(0, 1, 0, 0, 8'h10); run(300, 0);
    step(0, 0, 1, 0, 8'h10); run(600, 0);
    cur_tag = "R4"; step(0, 0, 0, 1, 8'h01); run(300, 0);
    step(0, 0, 1, 0, 8'h20); run(300, 0);
    step(0, 0, 0, 1, 8'h02); run(300, 0);
    step(0, 0, 0, 1, 8'h03); run(600, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 8'h00);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule